// File: doc/BRIEF.md
# Interlocked Handshake Bus Target Controller

This block drives the target end of a parallel data bus whose words move under a fully interlocked two-wire handshake. The local side offers one word at a time through a valid/ready pair. Each word carries the three phase lines the target must present: message, command/data and direction. When the direction line says target-to-initiator, the block puts the word and its odd parity bits on the bus. It waits a programmable number of clock cycles so that every line has settled, and then raises its request line. When the direction line says initiator-to-target, it releases the data lines and raises request after the same delay. It then takes the word the initiator places on the bus.

The acknowledge line comes from another clock domain and passes through a two-flop synchronizer. Request falls only once the synchronized acknowledge is seen high. The next word, and with it any change of the phase lines, is taken only once the synchronized acknowledge is seen low again. A static configuration input selects a wide bus with two byte lanes or a narrow bus that uses only the low lane.

Top module: `hs_target_ctrl`

## Requirements
- R1: While and after a synchronous reset, the request line, data output enable, phase lines and receive strobe are low, and the local ready output is high while the acknowledge input is low.
- R2: A word is taken on a rising edge where tx_valid and tx_ready are both high, and tx_ready is high only when the block is idle and the synchronized acknowledge is low. On that edge the phase lines load from tx_phase, with bit 2 as message, bit 1 as command/data and bit 0 as direction (1 = target to initiator).
- R3: For a word whose direction bit is 1, the cycle after it is taken the data output enable is high and the bus carries the word. Each byte lane's parity bit makes that lane's eight data bits plus parity hold an odd number of ones, with lane k on data bits 8k+7..8k and parity bit k.
- R4: Request rises exactly skew_cycles+1 clock cycles after the cycle in which the word was taken.
- R5: While request is high, the data and parity outputs do not change.
- R6: Request falls, and the data output enable drops, on the third rising edge after the acknowledge input goes high: two synchronizer edges, then one state-machine edge.
- R7: After request falls, no new word is taken and the phase lines do not change until the synchronized acknowledge has been seen low.
- R8: With wide_en low, driven data bits 15..8 and parity bit 1 are zero, and received data bits 15..8 are zero.
- R9: For a word whose direction bit is 0, the data output enable stays low and request follows the same timing. In the cycle request falls, rx_valid is high for exactly one cycle, and rx_data holds bus_db_in as sampled on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_en | input | 1 | Static bus width select: 1 = two lanes, 0 = low lane only |
| skew_cycles | input | SKEW_W | Settle delay, in cycles, between valid data and request |
| tx_valid | input | 1 | Local side offers a word |
| tx_ready | output | 1 | Block takes the offered word on this edge |
| tx_phase | input | 3 | Phase for the word: {message, command/data, direction} |
| tx_data | input | DATA_W | Word to drive when direction is target to initiator |
| rx_valid | output | 1 | One-cycle strobe: a word has been received |
| rx_data | output | DATA_W | Received word |
| bus_req | output | 1 | Request line to the initiator |
| bus_ack | input | 1 | Acknowledge line from the initiator (asynchronous) |
| bus_msg | output | 1 | Message phase line |
| bus_cd | output | 1 | Command/data phase line |
| bus_io | output | 1 | Direction phase line |
| bus_db_out | output | DATA_W | Data lines driven by the target |
| bus_dbp_out | output | LANES | Odd parity per byte lane |
| bus_db_oe | output | 1 | Data and parity output enable |
| bus_db_in | input | DATA_W | Data lines as driven by the initiator |

## Verification
Words are sent in both directions at skew settings of zero, one and six. Zero skew shows whether the delay counter has an off-by-one, and the longer settings check the exact gap before request. The initiator model answers either at once or after several cycles, and holds acknowledge high for different lengths of time. This tells a block that waits on the synchronized acknowledge level apart from one that waits a fixed time. Back-to-back offers with phase changes are presented while acknowledge is still high, which shows whether a word or a phase change could slip into the gap too early. Data patterns with all ones, all zeros and mixed lanes, sent in both wide and narrow mode, separate correct odd parity and lane masking from an even-parity or unmasked design.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SKEW,
    ST_REQ,
    ST_DRAIN
  } hs_state_e;

  typedef struct packed {
    logic msg;
    logic cd;
    logic io;
  } hs_phase_t;
endpackage

// File: rtl/hs_sync2.sv
module hs_sync2 (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= 1'b0;
      q    <= 1'b0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/hs_lane_parity.sv
module hs_lane_parity #(
  parameter int W = 8
) (
  input  logic [W-1:0] data,
  output logic         par
);
  // odd parity: data plus par always hold an odd number of ones
  assign par = ~(^data);
endmodule

// File: rtl/hs_skew_timer.sv
module hs_skew_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/hs_target_ctrl.sv
module hs_target_ctrl #(
  parameter int LANE_W = 8,
  parameter int LANES  = 2,
  parameter int SKEW_W = 8,
  localparam int DATA_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wide_en,
  input  logic [SKEW_W-1:0] skew_cycles,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [2:0]        tx_phase,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              bus_req,
  input  logic              bus_ack,
  output logic              bus_msg,
  output logic              bus_cd,
  output logic              bus_io,
  output logic [DATA_W-1:0] bus_db_out,
  output logic [LANES-1:0]  bus_dbp_out,
  output logic              bus_db_oe,
  input  logic [DATA_W-1:0] bus_db_in
);
  import hs_pkg::*;

  hs_state_e         st;
  hs_phase_t         ph_q;
  logic              ack_s;
  logic              accept;
  logic              skew_done;
  logic [LANES-1:0]  par_raw;
  logic [LANES-1:0]  par_sel;
  logic [DATA_W-1:0] tx_sel;
  logic [DATA_W-1:0] rx_sel;

  hs_sync2 u_ack_sync (
    .clk (clk),
    .rst (rst),
    .d   (bus_ack),
    .q   (ack_s)
  );

  // per-lane parity and width masking; lane 0 is always active
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic lane_on;
    assign lane_on = wide_en || (g == 0);

    hs_lane_parity #(.W(LANE_W)) u_par (
      .data (tx_data[g*LANE_W +: LANE_W]),
      .par  (par_raw[g])
    );

    assign tx_sel[g*LANE_W +: LANE_W] = lane_on ? tx_data[g*LANE_W +: LANE_W] : '0;
    assign rx_sel[g*LANE_W +: LANE_W] = lane_on ? bus_db_in[g*LANE_W +: LANE_W] : '0;
    assign par_sel[g] = lane_on & par_raw[g];
  end

  assign tx_ready = (st == ST_IDLE) && !ack_s;
  assign accept   = tx_ready && tx_valid;

  hs_skew_timer #(.W(SKEW_W)) u_skew (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_val (skew_cycles),
    .expired  (skew_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      ph_q        <= '0;
      bus_req     <= 1'b0;
      bus_db_oe   <= 1'b0;
      bus_db_out  <= '0;
      bus_dbp_out <= '0;
      rx_valid    <= 1'b0;
      rx_data     <= '0;
    end else begin
      rx_valid <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (accept) begin
            ph_q <= hs_phase_t'(tx_phase);
            if (tx_phase[0]) begin
              bus_db_oe   <= 1'b1;
              bus_db_out  <= tx_sel;
              bus_dbp_out <= par_sel;
            end else begin
              bus_db_oe <= 1'b0;
            end
            st <= ST_SKEW;
          end
        end
        ST_SKEW: begin
          if (skew_done) begin
            bus_req <= 1'b1;
            st      <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (ack_s) begin
            bus_req   <= 1'b0;
            bus_db_oe <= 1'b0;
            if (!ph_q.io) begin
              rx_valid <= 1'b1;
              rx_data  <= rx_sel;
            end
            st <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (!ack_s)
            st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign bus_msg = ph_q.msg;
  assign bus_cd  = ph_q.cd;
  assign bus_io  = ph_q.io;
endmodule

// File: rtl/hs_target_ctrl_chk.sv
module hs_target_ctrl_chk #(
  parameter int LANE_W = 8,
  parameter int LANES  = 2,
  localparam int DATA_W = LANE_W * LANES
) (
  input logic              clk,
  input logic              rst,
  input logic              wide_en,
  input logic              ack_s,
  input logic              bus_req,
  input logic              bus_msg,
  input logic              bus_cd,
  input logic              bus_io,
  input logic              bus_db_oe,
  input logic [DATA_W-1:0] bus_db_out,
  input logic [LANES-1:0]  bus_dbp_out,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rx_data,
  input logic              tx_ready
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) $past(rst) |-> !bus_req && !bus_db_oe && !rx_valid);

  // R2
  ready_needs_low_ack_chk: assert property (@(posedge clk) disable iff (rst) tx_ready |-> !ack_s);

  // R3
  lane0_odd_par_chk: assert property (@(posedge clk) disable iff (rst)
    bus_db_oe |-> (^{bus_db_out[LANE_W-1:0], bus_dbp_out[0]}) == 1'b1);

  // R3
  req_with_data_chk: assert property (@(posedge clk) disable iff (rst) bus_req && bus_io |-> bus_db_oe);

  // R4
  req_rise_ack_low_chk: assert property (@(posedge clk) disable iff (rst) $rose(bus_req) |-> !$past(ack_s));

  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req && $past(bus_req) |-> $stable(bus_db_out) && $stable(bus_dbp_out));

  // R6
  req_fall_after_ack_chk: assert property (@(posedge clk) disable iff (rst) $fell(bus_req) |-> $past(ack_s));

  // R7
  phase_gap_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable({bus_msg, bus_cd, bus_io}) |-> !$past(ack_s) && !$past(bus_req));

  // R8
  narrow_upper_chk: assert property (@(posedge clk) disable iff (rst)
    !wide_en && bus_db_oe |-> bus_db_out[DATA_W-1:LANE_W] == '0 && !bus_dbp_out[LANES-1]);

  // R9
  rx_dir_chk: assert property (@(posedge clk) disable iff (rst) rx_valid |-> !bus_io && $fell(bus_req));

  // R9
  rx_one_cycle_chk: assert property (@(posedge clk) disable iff (rst) rx_valid |=> !rx_valid);

  // R8
  rx_narrow_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid && !wide_en |-> rx_data[DATA_W-1:LANE_W] == '0);
endmodule

bind hs_target_ctrl hs_target_ctrl_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wide_en     (wide_en),
  .ack_s       (ack_s),
  .bus_req     (bus_req),
  .bus_msg     (bus_msg),
  .bus_cd      (bus_cd),
  .bus_io      (bus_io),
  .bus_db_oe   (bus_db_oe),
  .bus_db_out  (bus_db_out),
  .bus_dbp_out (bus_dbp_out),
  .rx_valid    (rx_valid),
  .rx_data     (rx_data),
  .tx_ready    (tx_ready)
);

// File: tb/hs_target_ctrl_test.sv
`timescale 1ns/1ps
module hs_target_ctrl_test;
  localparam int LW = 8;
  localparam int NL = 2;
  localparam int DW = LW * NL;
  localparam int SW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wide_en = 1'b1;
  logic [SW-1:0] skew_cycles = '0;
  logic          tx_valid = 1'b0;
  logic          tx_ready;
  logic [2:0]    tx_phase = '0;
  logic [DW-1:0] tx_data = '0;
  logic          rx_valid;
  logic [DW-1:0] rx_data;
  logic          bus_req;
  logic          bus_ack = 1'b0;
  logic          bus_msg, bus_cd, bus_io;
  logic [DW-1:0] bus_db_out;
  logic [NL-1:0] bus_dbp_out;
  logic          bus_db_oe;
  logic [DW-1:0] bus_db_in = '0;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int ack_dly = 0;
  int rel_dly = 0;
  logic [DW-1:0] pat = 16'h4C21;

  always #2.5 clk = ~clk;

  hs_target_ctrl #(.LANE_W(LW), .LANES(NL), .SKEW_W(SW)) uut (
    .clk(clk), .rst(rst), .wide_en(wide_en), .skew_cycles(skew_cycles),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_phase(tx_phase), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_data(rx_data), .bus_req(bus_req), .bus_ack(bus_ack),
    .bus_msg(bus_msg), .bus_cd(bus_cd), .bus_io(bus_io), .bus_db_out(bus_db_out),
    .bus_dbp_out(bus_dbp_out), .bus_db_oe(bus_db_oe), .bus_db_in(bus_db_in)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic odd_par(input logic [LW-1:0] b);
    int ones = 0;
    for (int i = 0; i < LW; i++) if (b[i]) ones++;
    return (ones % 2 == 0);
  endfunction

  // behavioural reference: stage 0 idle, 1 settling, 2 request high, 3 waiting ack low
  int            m_stage;
  int            m_cnt;
  bit [1:0]      m_seen;
  logic          m_req, m_oe, m_rxv;
  logic [2:0]    m_phase;
  logic [DW-1:0] m_db, m_rxd;
  logic [NL-1:0] m_dbp;

  always @(posedge clk) begin
    if (rst) begin
      m_stage = 0; m_cnt = 0; m_seen = 0;
      m_req = 0; m_oe = 0; m_rxv = 0; m_phase = 0; m_db = 0; m_rxd = 0; m_dbp = 0;
    end else begin
      bit a;
      a = m_seen[1];
      m_rxv = 0;
      if (m_stage == 0) begin
        if (tx_valid && !a) begin
          m_phase = tx_phase;
          if (tx_phase[0]) begin
            m_oe = 1;
            m_db = wide_en ? tx_data : {8'h00, tx_data[7:0]};
            m_dbp[0] = odd_par(tx_data[7:0]);
            m_dbp[1] = wide_en ? odd_par(tx_data[15:8]) : 1'b0;
          end else m_oe = 0;
          m_cnt = skew_cycles;
          m_stage = 1;
        end
      end else if (m_stage == 1) begin
        if (m_cnt == 0) begin m_req = 1; m_stage = 2; end
        else m_cnt--;
      end else if (m_stage == 2) begin
        if (a) begin
          m_req = 0; m_oe = 0;
          if (!m_phase[0]) begin
            m_rxv = 1;
            m_rxd = wide_en ? bus_db_in : {8'h00, bus_db_in[7:0]};
          end
          m_stage = 3;
        end
      end else begin
        if (!a) m_stage = 0;
      end
      m_seen = {m_seen[0], bus_ack};
    end
  end

  // compare against the reference away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      check("R4/R6", "bus_req", bus_req, m_req);
      check("R3", "bus_db_oe", bus_db_oe, m_oe);
      if (m_oe) begin
        check("R3/R5/R8", "bus_db_out", bus_db_out, m_db);
        check("R3/R8", "bus_dbp_out", bus_dbp_out, m_dbp);
      end
      check("R2/R7", "phase", {bus_msg, bus_cd, bus_io}, m_phase);
      check("R2/R7", "tx_ready", tx_ready, (m_stage == 0) && !m_seen[1]);
      check("R9", "rx_valid", rx_valid, m_rxv);
      if (m_rxv) check("R9/R8", "rx_data", rx_data, m_rxd);
    end
  end

  // initiator model
  initial begin
    forever begin
      @(negedge clk);
      if (bus_req && !bus_ack) begin
        bus_db_in = pat;
        pat = pat + 16'h3B1D;
        repeat (ack_dly) @(negedge clk);
        bus_ack = 1'b1;
      end else if (!bus_req && bus_ack) begin
        repeat (rel_dly) @(negedge clk);
        bus_ack = 1'b0;
      end
    end
  end

  // offers a word and holds it until taken, then measures the gap to request
  task automatic send(input logic [2:0] ph, input logic [DW-1:0] d);
    int n;
    tx_phase = ph;
    tx_data  = d;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    n = 0;
    while (!bus_req) begin n++; @(negedge clk); end
    // R4: request rises skew_cycles+1 cycles after the word is taken
    check("R4", "req delay", n, skew_cycles + 1);
  endtask

  task automatic settle();
    while (bus_req || bus_ack || !tx_ready) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset state
    check("R1", "req in reset", bus_req, 1'b0);
    check("R1", "oe in reset", bus_db_oe, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "phase after reset", {bus_msg, bus_cd, bus_io}, 3'b000);
    check("R1", "ready after reset", tx_ready, 1'b1);
    check("R1", "rx_valid after reset", rx_valid, 1'b0);

    // wide mode, zero skew, fast initiator
    skew_cycles = 0; ack_dly = 0; rel_dly = 0;
    send(3'b011, 16'hA5C3);
    send(3'b011, 16'hFFFF);
    send(3'b001, 16'h0000);
    send(3'b000, 16'h0000);
    send(3'b110, 16'h0000);
    settle();

    // slower initiator, longer skew, phase changes on every word
    skew_cycles = 6; ack_dly = 3; rel_dly = 5;
    send(3'b111, 16'h0180);
    send(3'b010, 16'h0000);
    send(3'b101, 16'h7E01);
    send(3'b001, 16'h8000);
    settle();
    // R7: phase held after drain with no new word
    check("R7", "phase held", {bus_msg, bus_cd, bus_io}, 3'b001);

    // narrow mode
    wide_en = 1'b0; skew_cycles = 1; ack_dly = 1; rel_dly = 2;
    send(3'b001, 16'hBEEF);
    send(3'b011, 16'h12FF);
    send(3'b000, 16'h0000);
    send(3'b100, 16'h0000);
    settle();
    // R8: received upper byte masked
    check("R8", "rx upper byte", rx_data[15:8], 8'h00);

    wide_en = 1'b1; skew_cycles = 2; ack_dly = 0; rel_dly = 7;
    send(3'b000, 16'h0000);
    send(3'b001, 16'h5A5A);
    settle();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule